// File: doc/BRIEF.md
# PHY Management Register Bank

This block models the management register set of a single Ethernet PHY as seen through a parallel request port. Each request names a PHY address, a register number and, for writes, 16 bits of data. Most registers are plain storage with fixed power-up contents. A few read values are built on the fly from the link state pin and the advertisement register, so status, partner ability and resolved speed/duplex follow what software advertised. Requests aimed at any other PHY address see an empty bus: reads return all ones and writes are dropped.

Requests use a valid/ready handshake. Read results leave on a valid/ready response channel that holds a single entry. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle. A stalled response keeps its data unchanged until `rsp_ready` takes it. Writes produce no response.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset, register 0 reads 0x3100, register 2 reads 0x0141, register 3 reads 0x0CC2, register 4 reads 0x01E1, all other stored registers read 0, `rsp_valid` is low and `req_ready` is high.
- R2: A read of register 1 returns 0x782E (bits 14, 13, 12, 11, 5, 3, 2 and 1 set) while `link_up` is high at acceptance, and 0x0000 while it is low.
- R3: A read of register 5 returns 0x4001 OR'd with bits 8:5 of register 4.
- R4: A read of register 17 returns 0x8C00 regardless of writes to it.
- R5: A read of register 18 with the link down returns 0; with the link up, bit 10 is set when register 4 bit 7 or bit 8 is set, bit 11 is set when register 4 bit 6 or bit 8 is set, all other bits zero.
- R6: Every register other than 1, 5, 17 and 18 reads back the last value written to it.
- R7: Any accepted write to the configured address, to any register, leaves bit 15 of register 0 cleared, including a write of register 0 with bit 15 set.
- R8: A read whose PHY address differs from `PHY_ADDR` returns 0xFFFF; a write to such an address changes no register.
- R9: An accepted read yields `rsp_valid` with its data in the next cycle; an accepted write yields no response; a write is visible to a read accepted in the following cycle.
- R10: `req_ready` equals `!rsp_valid || rsp_ready`, and while `rsp_valid` is high with `rsp_ready` low, `rsp_valid` and `rsp_rdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link state used for status and speed reads |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Consumer takes the read result |
| rsp_rdata | output | 16 | Read result |

## Verification
The bench builds the block with the default `PHY_ADDR` of 7 and a 5-bit address field, so one PHY in 32 answers. A quarter of the random requests go to other addresses, which brings the all-ones reads and dropped writes into frequent reach. Random back-pressure on `rsp_ready` keeps the single-entry response slot full for several cycles at a time. A slowly toggling `link_up` reaches both link states while the advertisement register takes arbitrary values.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int DW = 16;
  localparam int RIDX_W = 5;
  localparam int NREG = 1 << RIDX_W;

  localparam logic [RIDX_W-1:0] REG_CTRL = 5'd0;
  localparam logic [RIDX_W-1:0] REG_STAT = 5'd1;
  localparam logic [RIDX_W-1:0] REG_ID_HI = 5'd2;
  localparam logic [RIDX_W-1:0] REG_ID_LO = 5'd3;
  localparam logic [RIDX_W-1:0] REG_ADV = 5'd4;
  localparam logic [RIDX_W-1:0] REG_PARTNER = 5'd5;
  localparam logic [RIDX_W-1:0] REG_VENDOR = 5'd17;
  localparam logic [RIDX_W-1:0] REG_RESOLVED = 5'd18;

  localparam logic [DW-1:0] STAT_LINK_UP_VAL = 16'h782E;
  localparam logic [DW-1:0] PARTNER_BASE = 16'h4001;
  localparam logic [DW-1:0] VENDOR_CONST = 16'h8C00;
  localparam logic [DW-1:0] MISS_VAL = 16'hFFFF;
  localparam int CTRL_SELF_CLEAR_BIT = 15;

  function automatic logic [DW-1:0] reset_val(input int idx);
    case (idx)
      0: return 16'h3100;
      2: return 16'h0141;
      3: return 16'h0CC2;
      4: return 16'h01E1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/phy_mgmt_store.sv
module phy_mgmt_store
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RIDX_W-1:0] wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic [RIDX_W-1:0] rd_idx,
  output logic [DW-1:0]     rd_raw,
  output logic [3:0]        adv_abil
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          regs_q[g] <= reset_val(g);
        end else if (wr_en) begin
          if (wr_idx == RIDX_W'(g)) regs_q[g] <= wr_data;
          regs_q[g][CTRL_SELF_CLEAR_BIT] <= 1'b0;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n) regs_q[g] <= reset_val(g);
        else if (wr_en && wr_idx == RIDX_W'(g)) regs_q[g] <= wr_data;
      end
    end
  end

  assign rd_raw = regs_q[rd_idx];
  assign adv_abil = regs_q[REG_ADV][8:5];

  assert_ctrl_self_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !regs_q[0][CTRL_SELF_CLEAR_BIT]);
  assert_ctrl_untouched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != REG_CTRL) |=> regs_q[0][14:0] == $past(regs_q[0][14:0]));
endmodule

// File: rtl/phy_mgmt_view.sv
module phy_mgmt_view
  import phy_mgmt_pkg::*;
(
  input  logic [RIDX_W-1:0] reg_idx,
  input  logic [DW-1:0]     raw,
  input  logic [3:0]        adv_abil,
  input  logic              link_up,
  output logic [DW-1:0]     value
);
  logic adv_100;
  logic adv_full;

  assign adv_100 = adv_abil[2] | adv_abil[3];
  assign adv_full = adv_abil[1] | adv_abil[3];

  always_comb begin
    value = raw;
    case (reg_idx)
      REG_STAT:     value = link_up ? STAT_LINK_UP_VAL : '0;
      REG_PARTNER:  value = PARTNER_BASE | {7'd0, adv_abil, 5'd0};
      REG_VENDOR:   value = VENDOR_CONST;
      REG_RESOLVED: value = link_up ? {4'd0, adv_full, adv_100, 10'd0} : '0;
      default:      value = raw;
    endcase
  end
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
  import phy_mgmt_pkg::*;
#(
  parameter logic [RIDX_W-1:0] PHY_ADDR = 5'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [RIDX_W-1:0] req_phy,
  input  logic [RIDX_W-1:0] req_reg,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_rdata
);
  logic          accept;
  logic          hit;
  logic          wr_en;
  logic [DW-1:0] raw;
  logic [DW-1:0] view;
  logic [3:0]    adv_abil;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept = req_valid && req_ready;
  assign hit = (req_phy == PHY_ADDR);
  assign wr_en = accept && req_write && hit;

  phy_mgmt_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(req_reg),
    .wr_data(req_wdata), .rd_idx(req_reg), .rd_raw(raw), .adv_abil(adv_abil)
  );

  phy_mgmt_view u_view (
    .reg_idx(req_reg), .raw(raw), .adv_abil(adv_abil),
    .link_up(link_up), .value(view)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= hit ? view : MISS_VAL;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_miss_all_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && !hit) |=> (rsp_valid && rsp_rdata == MISS_VAL));
  assert_vendor_const_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && hit && req_reg == REG_VENDOR) |=> rsp_rdata == VENDOR_CONST);
  assert_status_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && hit && req_reg == REG_STAT && !link_up) |=> rsp_rdata == '0);
  assert_partner_fixed_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && hit && req_reg == REG_PARTNER) |=> (rsp_rdata[14] && rsp_rdata[0]));
  assert_read_responds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write) |=> rsp_valid);
  assert_write_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> !rsp_valid);
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

// File: tb/phy_mgmt_regfile_tb.sv
module phy_mgmt_regfile_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [4:0] req_phy = 5'd7;
  logic [4:0] req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] mdl [32];
  logic e_valid = 1'b0;
  logic [15:0] e_data = '0;
  string e_tag = "R9";

  always #5 clk = ~clk;

  phy_mgmt_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_phy(req_phy),
    .req_reg(req_reg), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [4:0] p, input logic [4:0] r, input logic lk);
    logic [15:0] v;
    if (p != 5'd7) return 16'hFFFF;
    case (r)
      5'd1: return lk ? 16'h782E : 16'h0000;
      5'd5: return 16'h4001 | (mdl[4] & 16'h01E0);
      5'd17: return 16'h8C00;
      5'd18: begin
        v = '0;
        if (lk && (mdl[4][7] || mdl[4][8])) v[10] = 1'b1;
        if (lk && (mdl[4][6] || mdl[4][8])) v[11] = 1'b1;
        return v;
      end
      default: return mdl[r];
    endcase
  endfunction

  function automatic string auto_tag(input logic [4:0] p, input logic [4:0] r);
    if (p != 5'd7) return "R8";
    case (r)
      5'd0: return "R7";
      5'd1: return "R2";
      5'd5: return "R3";
      5'd17: return "R4";
      5'd18: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic cyc(input logic v, input logic w, input logic [4:0] p, input logic [4:0] r,
                     input logic [15:0] d, input logic lk, input logic rr, input string tag);
    logic acc;
    req_valid = v; req_write = w; req_phy = p; req_reg = r; req_wdata = d;
    link_up = lk; rsp_ready = rr;
    #1;
    chk("R10 ready", {15'd0, req_ready}, {15'd0, (!e_valid || rr)});
    acc = v && (!e_valid || rr);
    if (acc && !w) begin
      e_valid = 1'b1;
      e_data = exp_read(p, r, lk);
      e_tag = tag;
    end else if (rr) begin
      e_valid = 1'b0;
    end
    if (acc && w && p == 5'd7) begin
      mdl[r] = d;
      mdl[0][15] = 1'b0;
    end
    @(negedge clk);
    chk("R9 valid", {15'd0, rsp_valid}, {15'd0, e_valid});
    if (e_valid) chk(e_tag, rsp_rdata, e_data);
  endtask

  task automatic rd(input logic [4:0] p, input logic [4:0] r, input logic lk, input string tag);
    cyc(1'b1, 1'b0, p, r, 16'h0, lk, 1'b1, tag);
  endtask

  task automatic wr(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    cyc(1'b1, 1'b1, p, r, d, 1'b1, 1'b1, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic lk;
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    mdl[0] = 16'h3100; mdl[2] = 16'h0141; mdl[3] = 16'h0CC2; mdl[4] = 16'h01E1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 rsp_valid", {15'd0, rsp_valid}, 16'd0);
    chk("R1 req_ready", {15'd0, req_ready}, 16'd1);
    @(negedge clk);
    // R1 reset contents
    rd(7, 0, 1, "R1"); rd(7, 2, 1, "R1"); rd(7, 3, 1, "R1"); rd(7, 4, 1, "R1"); rd(7, 9, 1, "R1");
    // R2 and R5 against link state
    rd(7, 1, 1, "R2"); rd(7, 1, 0, "R2"); rd(7, 18, 0, "R5"); rd(7, 18, 1, "R5");
    // R3 / R5 follow advertisement
    wr(7, 4, 16'h0140); rd(7, 18, 1, "R5"); rd(7, 5, 1, "R3");
    wr(7, 4, 16'h0080); rd(7, 18, 1, "R5");
    wr(7, 4, 16'h0020); rd(7, 18, 1, "R5"); rd(7, 5, 1, "R3");
    // R7 self-clearing bit
    wr(7, 0, 16'h9234); rd(7, 0, 1, "R7");
    // R4 constant, R6 plain storage
    wr(7, 17, 16'h1111); rd(7, 17, 1, "R4");
    wr(7, 9, 16'hA5A5); rd(7, 9, 1, "R6"); rd(7, 1, 1, "R2");
    // R8 foreign address
    wr(3, 9, 16'hDEAD); rd(7, 9, 1, "R8"); rd(3, 9, 1, "R8");
    wr(3, 0, 16'h8000); rd(7, 0, 1, "R8");
    // R10 back-pressure
    cyc(1, 0, 7, 2, 0, 1, 0, "R10");
    cyc(1, 0, 7, 3, 0, 1, 0, "R10");
    cyc(0, 0, 7, 3, 0, 1, 0, "R10");
    cyc(1, 1, 7, 4, 16'hFFFF, 1, 0, "R10");
    cyc(0, 0, 7, 0, 0, 1, 1, "R10");
    rd(7, 4, 1, "R6");
    // random phase
    lk = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      logic v, w, rr;
      logic [4:0] p, r;
      logic [15:0] d;
      int sel;
      v = ($urandom % 4) != 0;
      w = ($urandom % 3) == 0;
      p = (($urandom % 4) == 0) ? 5'($urandom) : 5'd7;
      sel = $urandom % 10;
      case (sel)
        0: r = 5'd0; 1: r = 5'd1; 2: r = 5'd4; 3: r = 5'd5;
        4: r = 5'd17; 5: r = 5'd18; default: r = 5'($urandom);
      endcase
      d = 16'($urandom);
      if (($urandom % 20) == 0) lk = ~lk;
      rr = ($urandom % 4) != 0;
      cyc(v, w, p, r, d, lk, rr, auto_tag(p, r));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule